// File: doc/BRIEF.md
# External Bus Turnaround Wait Inserter

This block connects a simple internal request port to an external static-memory bus. The bus has six active-low chip selects, an active-low read strobe, per-byte active-low write strobes, per-byte active-low byte selects, an address bus and a data bus with an output enable. The block runs one access at a time. Each access is built from fixed-length phases: one setup cycle, a strobe phase of `STRB_CYC` cycles (two by default) and one hold cycle.

When a new request is accepted in the hold cycle of the previous access, the block checks whether the bus needs a turnaround gap. A switch to a different chip select gets exactly one idle cycle, with every control line forced high. A write followed by a read on the same chip select gets one early-read idle cycle. The two waits never stack. Any other back-to-back pair runs with no gap, and an access that starts from an idle bus never waits.

Requests use a valid/ready handshake. A request with a chip-select index the bus does not have is answered with an error pulse and produces no bus activity. Read data comes back on a one-cycle response pulse.

Top module: `ebus_turnaround`

## Requirements
- R1: While reset is asserted, and until the internal reset release completes, `req_ready` is low, every control line is high and `bus_doe` is low. After that, `req_ready` is high in idle cycles and in hold cycles, and low in setup, strobe and wait cycles. A request is accepted at a clock edge where `req_valid` and `req_ready` are both high.
- R2: If a request is accepted in the hold cycle of an access and targets a different chip select, exactly one wait cycle lies between that hold cycle and the new setup cycle.
- R3: In every wait cycle, all `bus_cs_n`, `bus_be_n` and `bus_wr_n` bits and `bus_rd_n` are high, `bus_doe` is low and `req_ready` is low.
- R4: If a write is followed back to back (accepted in its hold cycle) by a read on the same chip select, exactly one wait cycle is inserted.
- R5: A write on one chip select followed back to back by a read on another chip select gets exactly one wait cycle in total, not two.
- R6: Back-to-back read-read, write-write and read-write pairs on the same chip select have no wait: the new setup cycle immediately follows the hold cycle.
- R7: A request accepted while the bus is idle (first access after reset, or after at least one idle cycle) begins its setup cycle in the cycle right after acceptance.
- R8: A request with `req_cs` of 6 or 7 produces a one-cycle `rsp_valid` pulse with `rsp_err` high in the cycle after acceptance, and no chip select, strobe, byte select or output enable changes for it.
- R9: Phase sequence of an accepted access. In setup, the selected `bus_cs_n[req_cs]` is low, every other chip select is high, `bus_be_n` is the inverse of `req_be`, and the strobes are high. Then `STRB_CYC` strobe cycles follow: `bus_rd_n` is low for a read, and `bus_wr_n` is the inverse of `req_be` for a write. Then one hold cycle, with the strobes high and the chip select and byte selects still low. Through all three phases `bus_addr` shows the request address.
- R10: `bus_doe` is high only in the setup, strobe and hold cycles of a write, and `bus_dout` then carries the write data. `bus_doe` is low in every wait and idle cycle and for every read.
- R11: A read produces `rsp_valid` high with `rsp_err` low for exactly its hold cycle. `rsp_rdata` equals `bus_din` as sampled in the last strobe cycle. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Chip-select index, 0 to 5 valid |
| req_addr | input | AW (16) | Access address |
| req_wdata | input | DW (32) | Write data |
| req_be | input | DW/8 (4) | Byte enables, active high |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is an error for a bad chip-select index |
| rsp_rdata | output | DW (32) | Read data |
| bus_cs_n | output | NCS (6) | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | DW/8 (4) | Active-low per-byte write strobes |
| bus_be_n | output | DW/8 (4) | Active-low byte selects |
| bus_addr | output | AW (16) | External address |
| bus_dout | output | DW (32) | External write data |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | DW (32) | External read data |

## Verification
The assertions take for granted two things about the inputs. No request is offered while reset is low. `bus_din` is settled during the last strobe cycle of a read. The stimulus raises `req_valid` only after the reset release has been waited out. It models the external device as a pure function of the held address, so the data is stable across the whole strobe phase. Requests are offered both on the hold cycle of the previous access and after idle gaps, so the checks see the back-to-back and the from-idle turnaround decisions.

// File: rtl/ebt_pkg.sv
package ebt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_WAIT_CS = 3'd1,
    PH_WAIT_ER = 3'd2,
    PH_SETUP   = 3'd3,
    PH_STROBE  = 3'd4,
    PH_HOLD    = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    TURN_NONE = 2'd0,
    TURN_CS   = 2'd1,
    TURN_ER   = 2'd2
  } turn_e;
endpackage

// File: rtl/ebt_rst_sync.sv
module ebt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok = sh_q[STAGES-1];
endmodule

// File: rtl/ebt_turn_policy.sv
module ebt_turn_policy import ebt_pkg::*; #(
  parameter int CSW = 3
) (
  input  logic           prev_valid,
  input  logic [CSW-1:0] prev_cs,
  input  logic           prev_write,
  input  logic [CSW-1:0] next_cs,
  input  logic           next_write,
  output turn_e          turn
);
  // A device switch takes precedence; the early-read gap is only
  // considered when the device stays the same.
  always_comb begin
    turn = TURN_NONE;
    if (prev_valid) begin
      if (prev_cs != next_cs)             turn = TURN_CS;
      else if (prev_write && !next_write) turn = TURN_ER;
    end
  end
endmodule

// File: rtl/ebt_seq.sv
module ebt_seq import ebt_pkg::*; #(
  parameter int NCS      = 6,
  parameter int CSW      = 3,
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int NB       = 4,
  parameter int STRB_CYC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [CSW-1:0] req_cs,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [NB-1:0]  req_be,
  output logic           req_ready,
  input  logic [DW-1:0]  bus_din,
  output phase_e         phase,
  output logic [CSW-1:0] cur_cs,
  output logic           cur_write,
  output logic [NB-1:0]  cur_be,
  output logic [AW-1:0]  cur_addr,
  output logic [DW-1:0]  cur_wdata,
  output logic           rsp_valid,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_rdata
);
  localparam int CNTW = (STRB_CYC > 1) ? $clog2(STRB_CYC) : 1;
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(STRB_CYC - 1);
  localparam logic [CSW:0]    NCS_W    = (CSW+1)'(NCS);

  phase_e          phase_q, phase_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            cs_ok, accept, load, bad, cap, in_hold;
  turn_e           turn;

  assign in_hold   = (phase_q == PH_HOLD);
  assign req_ready = run && ((phase_q == PH_IDLE) || in_hold);
  assign cs_ok     = ({1'b0, req_cs} < NCS_W);
  assign accept    = req_valid && req_ready;
  assign load      = accept && cs_ok;
  assign bad       = accept && !cs_ok;
  assign cap       = (phase_q == PH_STROBE) && (cnt_q == '0) && !cur_write;

  ebt_turn_policy #(.CSW(CSW)) u_pol (
    .prev_valid (in_hold),
    .prev_cs    (cur_cs),
    .prev_write (cur_write),
    .next_cs    (req_cs),
    .next_write (req_write),
    .turn       (turn)
  );

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (load) phase_d = PH_SETUP;
      end
      PH_WAIT_CS, PH_WAIT_ER: begin
        phase_d = PH_SETUP;
      end
      PH_SETUP: begin
        phase_d = PH_STROBE;
        cnt_d   = CNT_LAST;
      end
      PH_STROBE: begin
        if (cnt_q == '0) phase_d = PH_HOLD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      PH_HOLD: begin
        if (load) begin
          unique case (turn)
            TURN_CS: phase_d = PH_WAIT_CS;
            TURN_ER: phase_d = PH_WAIT_ER;
            default: phase_d = PH_SETUP;
          endcase
        end else begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      cur_cs    <= '0;
      cur_write <= 1'b0;
      cur_be    <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      cnt_q     <= cnt_d;
      rsp_valid <= cap || bad;
      rsp_err   <= bad;
      if (load) begin
        cur_cs    <= req_cs;
        cur_write <= req_write;
        cur_be    <= req_be;
      end
    end
  end

  // data registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (load) begin
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
    end
    if (cap) rsp_rdata <= bus_din;
  end

  assign phase = phase_q;
endmodule

// File: rtl/ebt_pin_drive.sv
module ebt_pin_drive import ebt_pkg::*; #(
  parameter int NCS = 6,
  parameter int CSW = 3,
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int NB  = 4
) (
  input  phase_e         phase,
  input  logic [CSW-1:0] cur_cs,
  input  logic           cur_write,
  input  logic [NB-1:0]  cur_be,
  input  logic [AW-1:0]  cur_addr,
  input  logic [DW-1:0]  cur_wdata,
  output logic [NCS-1:0] bus_cs_n,
  output logic           bus_rd_n,
  output logic [NB-1:0]  bus_wr_n,
  output logic [NB-1:0]  bus_be_n,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_doe
);
  logic active, strobe;

  assign active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign strobe = (phase == PH_STROBE);

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign bus_cs_n[g] = !(active && (cur_cs == CSW'(g)));
  end

  assign bus_be_n = active ? ~cur_be : '1;
  assign bus_rd_n = !(strobe && !cur_write);
  assign bus_wr_n = (strobe && cur_write) ? ~cur_be : '1;
  assign bus_doe  = active && cur_write;
  assign bus_addr = cur_addr;
  assign bus_dout = cur_wdata;
endmodule

// File: rtl/ebus_turnaround.sv
module ebus_turnaround import ebt_pkg::*; #(
  parameter int NCS      = 6,
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int STRB_CYC = 2,
  localparam int CSW     = $clog2(NCS),
  localparam int NB      = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [CSW-1:0] req_cs,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [NB-1:0]  req_be,
  output logic           rsp_valid,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_rdata,
  output logic [NCS-1:0] bus_cs_n,
  output logic           bus_rd_n,
  output logic [NB-1:0]  bus_wr_n,
  output logic [NB-1:0]  bus_be_n,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_doe,
  input  logic [DW-1:0]  bus_din
);
  logic           run;
  phase_e         phase;
  logic [CSW-1:0] cur_cs;
  logic           cur_write;
  logic [NB-1:0]  cur_be;
  logic [AW-1:0]  cur_addr;
  logic [DW-1:0]  cur_wdata;

  ebt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (run)
  );

  ebt_seq #(
    .NCS(NCS), .CSW(CSW), .AW(AW), .DW(DW), .NB(NB), .STRB_CYC(STRB_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_cs    (req_cs),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .req_ready (req_ready),
    .bus_din   (bus_din),
    .phase     (phase),
    .cur_cs    (cur_cs),
    .cur_write (cur_write),
    .cur_be    (cur_be),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  ebt_pin_drive #(
    .NCS(NCS), .CSW(CSW), .AW(AW), .DW(DW), .NB(NB)
  ) u_pin (
    .phase     (phase),
    .cur_cs    (cur_cs),
    .cur_write (cur_write),
    .cur_be    (cur_be),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_be_n  (bus_be_n),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe)
  );
endmodule

// File: rtl/ebus_turnaround_chk.sv
module ebus_turnaround_chk #(
  parameter int NCS = 6,
  parameter int NB  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic           rsp_err,
  input logic [NCS-1:0] bus_cs_n,
  input logic           bus_rd_n,
  input logic [NB-1:0]  bus_wr_n,
  input logic           bus_doe
);
  // R9: at most one device selected at a time
  p_cs_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  // R9: the read strobe only moves with a device selected
  p_rd_with_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (bus_cs_n != '1));

  // R10: output enable never overlaps the read strobe
  p_doe_write_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> bus_rd_n);

  // R3: with no device selected the data bus is released
  p_idle_doe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs_n == '1) |-> !bus_doe);

  // R2: two different devices are never selected in adjacent cycles
  p_cs_switch_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_cs_n != '1) && ($past(bus_cs_n) != '1)) |-> (bus_cs_n == $past(bus_cs_n)));

  // R8: an error response comes with a quiet bus
  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> ((bus_cs_n == '1) && !bus_doe));

  // R1: no request is taken while a strobe is active
  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || (bus_wr_n != '1)) |-> !req_ready);

  // R11: a read response appears in the hold cycle
  p_rsp_in_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (bus_rd_n && (bus_cs_n != '1) && !bus_doe && req_ready));
endmodule

bind ebus_turnaround ebus_turnaround_chk #(.NCS(NCS), .NB(NB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .bus_cs_n  (bus_cs_n),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .bus_doe   (bus_doe)
);

// File: tb/sim_ebus_turnaround.sv
module sim_ebus_turnaround;
  localparam int CLK_PERIOD = 10;
  localparam int STRB       = 2;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [2:0]  req_cs;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_be;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [5:0]  bus_cs_n;
  logic        bus_rd_n, bus_doe;
  logic [3:0]  bus_wr_n, bus_be_n;
  logic [15:0] bus_addr;
  logic [31:0] bus_dout, bus_din;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  function automatic logic [31:0] dev_data(input logic [15:0] a);
    return {~a, a} ^ 32'h5A5A_3C3C;
  endfunction

  assign bus_din = dev_data(bus_addr);

  ebus_turnaround u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_be_n(bus_be_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // expected per-cycle slots: kind 0 idle, 1 wait, 2 setup, 3 strobe, 4 hold
  int          ex_kind [16];
  logic [2:0]  ex_cs   [16];
  logic        ex_wr   [16];
  logic [3:0]  ex_be   [16];
  logic [15:0] ex_addr [16];
  logic [31:0] ex_wd   [16];
  logic        ex_rsp  [16];
  logic        ex_err  [16];
  logic [31:0] ex_rd   [16];
  string       ex_tag  [16];
  string       ex_rtag [16];

  int         last_hold = -10;
  logic [2:0] last_cs   = 3'd0;
  logic       last_wr   = 1'b0;

  function automatic int exp_wait(input bit b2b, input logic [2:0] pcs, input logic pwr,
                                  input logic [2:0] ncs, input logic nwr);
    if (!b2b)       return 0;
    if (pcs != ncs) return 1;
    if (pwr && !nwr) return 1;
    return 0;
  endfunction

  task automatic clear_slot(input int i);
    ex_kind[i] = 0; ex_cs[i] = 0; ex_wr[i] = 0; ex_be[i] = 0;
    ex_addr[i] = 0; ex_wd[i] = 0; ex_rsp[i] = 0; ex_err[i] = 0;
    ex_rd[i] = 0; ex_tag[i] = "R1 idle"; ex_rtag[i] = "R11";
  endtask

  task automatic fill(input int t, input int kind, input string tag);
    int i = t % 16;
    ex_kind[i] = kind; ex_cs[i] = req_cs; ex_wr[i] = req_write; ex_be[i] = req_be;
    ex_addr[i] = req_addr; ex_wd[i] = req_wdata; ex_tag[i] = tag;
  endtask

  task automatic schedule(input int t);
    if (req_valid && req_ready) begin
      if (req_cs >= 3'd6) begin
        ex_rsp[(t+1)%16] = 1'b1; ex_err[(t+1)%16] = 1'b1; ex_rtag[(t+1)%16] = "R8";
        ex_tag[(t+1)%16] = "R8 quiet bus";
      end else begin
        bit b2b = (t == last_hold);
        int w = exp_wait(b2b, last_cs, last_wr, req_cs, req_write);
        string wt, st;
        int s;
        if (last_cs != req_cs) wt = (last_wr && !req_write) ? "R5 R3" : "R2 R3";
        else                   wt = "R4 R3";
        st = !b2b ? "R7 R9" : (w != 0 ? wt : "R6 R9");
        s = t + 1 + w;
        if (w != 0) fill(t+1, 1, wt);
        fill(s, 2, st);
        for (int k = 1; k <= STRB; k++) fill(s+k, 3, "R9 R10");
        fill(s+STRB+1, 4, "R9 R10");
        if (!req_write) begin
          ex_rsp[(s+STRB+1)%16] = 1'b1;
          ex_rd[(s+STRB+1)%16]  = dev_data(req_addr);
          ex_rtag[(s+STRB+1)%16] = "R11";
        end
        last_hold = s + STRB + 1;
        last_cs   = req_cs;
        last_wr   = req_write;
      end
    end
  endtask

  task automatic check_cycle(input int t);
    int i = t % 16;
    int k = ex_kind[i];
    bit act = (k >= 2);
    logic [5:0] e_cs  = act ? ~(6'b1 << ex_cs[i]) : 6'h3F;
    logic       e_rd  = !(k == 3 && !ex_wr[i]);
    logic [3:0] e_wr  = (k == 3 && ex_wr[i]) ? ~ex_be[i] : 4'hF;
    logic [3:0] e_be  = act ? ~ex_be[i] : 4'hF;
    logic       e_oe  = act && ex_wr[i];
    logic       e_rdy = (k == 0 || k == 4);
    bit ok;
    n_chk++;
    ok = (bus_cs_n == e_cs) && (bus_rd_n == e_rd) && (bus_wr_n == e_wr) &&
         (bus_be_n == e_be) && (bus_doe == e_oe);
    if (act && bus_addr != ex_addr[i]) ok = 0;
    if (act && ex_wr[i] && bus_dout != ex_wd[i]) ok = 0;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cyc %0d bus: cs_n=%b rd_n=%b wr_n=%b be_n=%b doe=%b addr=%h dout=%h expected cs_n=%b rd_n=%b wr_n=%b be_n=%b doe=%b addr=%h dout=%h",
               ex_tag[i], t, bus_cs_n, bus_rd_n, bus_wr_n, bus_be_n, bus_doe, bus_addr, bus_dout,
               e_cs, e_rd, e_wr, e_be, e_oe, ex_addr[i], ex_wd[i]);
    end
    n_chk++;
    if (req_ready != e_rdy) begin
      n_bad++;
      $display("FAIL R1 cyc %0d ready=%b expected %b", t, req_ready, e_rdy);
    end
    n_chk++;
    ok = (rsp_valid == ex_rsp[i]);
    if (ok && ex_rsp[i]) begin
      if (rsp_err != ex_err[i]) ok = 0;
      if (!ex_err[i] && rsp_rdata != ex_rd[i]) ok = 0;
    end
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cyc %0d rsp valid=%b err=%b data=%h expected valid=%b err=%b data=%h",
               ex_rtag[i], t, rsp_valid, rsp_err, rsp_rdata, ex_rsp[i], ex_err[i], ex_rd[i]);
    end
    clear_slot(i);
  endtask

  task automatic tick();
    schedule(cyc);
    @(negedge clk);
    cyc++;
    check_cycle(cyc);
  endtask

  task automatic send(input bit wr, input logic [2:0] cs, input logic [15:0] a,
                      input logic [31:0] d, input logic [3:0] be);
    bit acc;
    req_valid = 1'b1; req_write = wr; req_cs = cs; req_addr = a; req_wdata = d; req_be = be;
    do begin
      acc = req_ready;
      tick();
    end while (!acc);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 16; i++) clear_slot(i);
    req_valid = 0; req_write = 0; req_cs = 0; req_addr = 0; req_wdata = 0; req_be = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    n_chk++;
    if (req_ready !== 1'b0 || bus_cs_n !== 6'h3F || bus_rd_n !== 1'b1 || bus_wr_n !== 4'hF ||
        bus_be_n !== 4'hF || bus_doe !== 1'b0 || rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset state ready=%b cs_n=%b rd_n=%b wr_n=%b be_n=%b doe=%b rsp=%b expected 0 111111 1 1111 1111 0 0",
               req_ready, bus_cs_n, bus_rd_n, bus_wr_n, bus_be_n, bus_doe, rsp_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cyc = 100;
    check_cycle(cyc);

    // directed corner cases
    send(0, 3'd0, 16'h0010, 32'h0, 4'hF);            // R7 from idle
    send(1, 3'd0, 16'h0020, 32'h1111_2222, 4'h3);    // R6 read-write same
    send(1, 3'd0, 16'h0024, 32'h3333_4444, 4'hC);    // R6 write-write
    send(0, 3'd0, 16'h0028, 32'h0, 4'hF);            // R4 write-read same
    send(0, 3'd0, 16'h002C, 32'h0, 4'hF);            // R6 read-read
    send(0, 3'd3, 16'h0030, 32'h0, 4'hF);            // R2 switch
    send(1, 3'd1, 16'h0040, 32'hDEAD_BEEF, 4'hF);    // R2 switch
    send(0, 3'd2, 16'h0050, 32'h0, 4'h1);            // R5 write then read elsewhere
    send(0, 3'd6, 16'h0060, 32'h0, 4'hF);            // R8
    send(1, 3'd7, 16'h0070, 32'h5555_AAAA, 4'hF);    // R8
    idle(2);
    send(1, 3'd5, 16'h0080, 32'h0BAD_F00D, 4'h6);    // R7 after idle
    idle(1);
    send(0, 3'd5, 16'h0084, 32'h0, 4'hF);            // R7 no early-read wait after gap
    send(1, 3'd4, 16'h0088, 32'h1234_5678, 4'hF);
    send(0, 3'd7, 16'h0000, 32'h0, 4'hF);            // R8 in hold
    send(0, 3'd4, 16'h008C, 32'h0, 4'hF);            // R7 after error gap
    idle(3);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] cs;
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
      cs = (($urandom % 2) == 0) ? last_cs : 3'($urandom % 8);
      send(1'($urandom % 2), cs, 16'($urandom), $urandom, 4'(($urandom % 15) + 1));
    end
    idle(8);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule